// File: doc/BRIEF.md
# E1 Transmit Error Injector

This block sits in the outgoing path of a 2.048 Mbit/s framer. It has two stages. The bit stage receives the assembled frame one bit per enabled cycle, together with the frame, timeslot and bit counters of the CRC-4 multiframe. It can invert a single chosen bit to create a frame-alignment, non-alignment, CRC-4 or payload error. It can also hold the E1 or E2 remote error-indication bit at zero. The line stage receives the positive and negative rail pulses from the line encoder. It can bend one mark into a bipolar violation, or silence both rails to imitate a loss of signal.

Software writes a single 8-bit control word. Each of the five error classes is armed by a one-cycle pulse on its bit. An armed class fires exactly once, at the first eligible position after the cycle in which it was armed, and then disarms. The loss-of-signal bit and the two E-bit bits are levels and act for as long as they stay high. Both stages have one enabled cycle of latency.

Top module: `e1_tx_err_inject`

## Requirements
- R1: After reset, `dout`, `p_out` and `n_out` are 0 and no error class is armed.
- R2: A pulse on `inj_ctrl[2]` inverts the first later bit with `ts_idx`=0, even `frm_idx` and `bit_idx`=1, which is the first bit of the 7-bit alignment word.
- R3: A pulse on `inj_ctrl[3]` inverts the first later bit with `ts_idx`=0, odd `frm_idx` and `bit_idx`=1.
- R4: A pulse on `inj_ctrl[1]` inverts the first later C1 bit. C1 is the bit at `ts_idx`=0, `bit_idx`=0 with `frm_idx` equal to 0 or 8, the start of each submultiframe.
- R5: A pulse on `inj_ctrl[4]` inverts the first later bit with `ts_idx`≠0 and `bit_idx`=0.
- R6: Every armed class causes exactly one inversion and then disarms. All other bits pass to `dout` unchanged, one enabled cycle later. `bit_idx`=0 is the first bit sent in a timeslot.
- R7: While `inj_ctrl[6]` is high, the bit at `frm_idx`=13, `ts_idx`=0, `bit_idx`=0 is sent as 0.
- R8: While `inj_ctrl[7]` is high, the bit at `frm_idx`=15, `ts_idx`=0, `bit_idx`=0 is sent as 0.
- R9: A pulse on `inj_ctrl[0]` makes the next mark, once any mark has been sent since reset, leave on the same rail as the previous sent mark. A space passes as a space, and later marks pass unchanged.
- R10: While `inj_ctrl[5]` is high, both rails are 0 whatever the encoder sends. No violation is produced during that time. A violation armed before or during this time applies to the first mark after release, relative to the last mark sent before it.
- R11: Classes armed in the same cycle act independently, each at its own position.
- R12: In a cycle with `bit_en` low, `dout`, `p_out` and `n_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One line bit per high cycle |
| bit_in | input | 1 | Assembled frame bit |
| frm_idx | input | 4 | Frame number within the CRC-4 multiframe |
| ts_idx | input | 5 | Timeslot number within the frame |
| bit_idx | input | 3 | Bit number within the timeslot, 0 sent first |
| inj_ctrl | input | 8 | Control word: [0] violation, [1] CRC, [2] alignment, [3] non-alignment, [4] payload, [5] signal loss, [6] E1, [7] E2 |
| p_in | input | 1 | Positive pulse from the line encoder |
| n_in | input | 1 | Negative pulse from the line encoder |
| dout | output | 1 | Bit stream after injection |
| p_out | output | 1 | Positive rail to the line |
| n_out | output | 1 | Negative rail to the line |

## Verification
The bench arms each error class both at and just past its own eligible position, and checks the distance to the single inverted bit. A design that let the arming cycle itself qualify, or that ignored frame parity, would land one position or one frame early. Long windows after each firing expose a class that never disarms: it keeps corrupting every later frame or submultiframe. The line tests arm a violation while the rails are silenced. A design that dropped that request, or that measured the violation against a mark swallowed during the silence, would put the pulse on the wrong rail.

// File: rtl/e1_inj_pkg.sv
package e1_inj_pkg;
  localparam int NUM_REQ  = 5;
  localparam int CTRL_W   = 8;
  localparam int REQ_BPV  = 0;
  localparam int REQ_CRC  = 1;
  localparam int REQ_FAS  = 2;
  localparam int REQ_NFAS = 3;
  localparam int REQ_PAY  = 4;
  localparam int CTL_LOS  = 5;
  localparam int CTL_E1   = 6;
  localparam int CTL_E2   = 7;

  typedef struct packed {
    logic p;
    logic n;
  } rail_t;
endpackage

// File: rtl/e1_inj_pending.sv
module e1_inj_pending #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] hit,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_d;
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_cls
    always_comb begin
      pend_d[i] = (pend_q[i] & ~hit[i]) | req[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/e1_inj_bitpath.sv
module e1_inj_bitpath
  import e1_inj_pkg::*;
#(
  parameter int FR_W        = 4,
  parameter int TS_W        = 5,
  parameter int BN_W        = 3,
  parameter int SMF_LEN     = 8,
  parameter int E1_FRAME    = 13,
  parameter int E2_FRAME    = 15,
  parameter int FAS_ERR_BIT = 1,
  parameter int NFAS_BIT    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               bit_in,
  input  logic [FR_W-1:0]    frm,
  input  logic [TS_W-1:0]    ts,
  input  logic [BN_W-1:0]    bn,
  input  logic [NUM_REQ-1:0] pend,
  input  logic               e1_frc,
  input  logic               e2_frc,
  output logic [NUM_REQ-1:0] hit,
  output logic               dout
);
  localparam int SMF_W = $clog2(SMF_LEN);

  logic [NUM_REQ-1:0] pos;
  logic               ts0;
  logic               force_zero;
  logic               dout_d;
  logic               dout_q;

  always_comb begin
    ts0            = (ts == '0);
    pos            = '0;
    pos[REQ_CRC]   = ts0 && (bn == '0) && (frm[SMF_W-1:0] == '0);
    pos[REQ_FAS]   = ts0 && !frm[0] && (bn == BN_W'(FAS_ERR_BIT));
    pos[REQ_NFAS]  = ts0 &&  frm[0] && (bn == BN_W'(NFAS_BIT));
    pos[REQ_PAY]   = !ts0 && (bn == '0);
    hit            = pos & pend & {NUM_REQ{bit_en}};
    force_zero     = ts0 && (bn == '0) &&
                     ((e1_frc && (frm == FR_W'(E1_FRAME))) ||
                      (e2_frc && (frm == FR_W'(E2_FRAME))));
    dout_d         = force_zero ? 1'b0 : (bit_in ^ (|hit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout_q <= 1'b0;
    else if (bit_en) dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/e1_inj_railpath.sv
module e1_inj_railpath
  import e1_inj_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic p_in,
  input  logic n_in,
  input  logic los,
  input  logic bpv_pend,
  output logic bpv_hit,
  output logic p_out,
  output logic n_out
);
  rail_t out_d, out_q;
  logic  mark;
  logic  last_p_d, last_p_q;
  logic  seen_d, seen_q;

  always_comb begin
    mark     = p_in | n_in;
    bpv_hit  = bit_en & bpv_pend & mark & seen_q & ~los;
    if (los)          out_d = '0;
    else if (bpv_hit) out_d = '{p: last_p_q, n: ~last_p_q};
    else              out_d = '{p: p_in, n: n_in};
    last_p_d = last_p_q;
    seen_d   = seen_q;
    if (bit_en && !los && mark) begin
      last_p_d = out_d.p;
      seen_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      last_p_q <= 1'b0;
      seen_q   <= 1'b0;
    end else if (bit_en) begin
      out_q    <= out_d;
      last_p_q <= last_p_d;
      seen_q   <= seen_d;
    end
  end

  assign p_out = out_q.p;
  assign n_out = out_q.n;
endmodule

// File: rtl/e1_tx_err_inject.sv
module e1_tx_err_inject
  import e1_inj_pkg::*;
#(
  parameter int TS_PER_FRAME  = 32,
  parameter int BITS_PER_TS   = 8,
  parameter int FRAMES_PER_MF = 16,
  parameter int SMF_LEN       = 8,
  parameter int E1_FRAME      = 13,
  parameter int E2_FRAME      = 15,
  parameter int FAS_ERR_BIT   = 1,
  localparam int FR_W = $clog2(FRAMES_PER_MF),
  localparam int TS_W = $clog2(TS_PER_FRAME),
  localparam int BN_W = $clog2(BITS_PER_TS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic [FR_W-1:0]   frm_idx,
  input  logic [TS_W-1:0]   ts_idx,
  input  logic [BN_W-1:0]   bit_idx,
  input  logic [CTRL_W-1:0] inj_ctrl,
  input  logic              p_in,
  input  logic              n_in,
  output logic              dout,
  output logic              p_out,
  output logic              n_out
);
  logic [1:0]         rst_sync;
  logic               core_rst_n;
  logic [NUM_REQ-1:0] pend;
  logic [NUM_REQ-1:0] hit_bit;
  logic [NUM_REQ-1:0] hit_all;
  logic               bpv_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  always_comb begin
    hit_all          = hit_bit;
    hit_all[REQ_BPV] = bpv_hit;
  end

  e1_inj_pending #(.N(NUM_REQ)) u_pend (
    .clk  (clk),
    .rst_n(core_rst_n),
    .req  (inj_ctrl[NUM_REQ-1:0]),
    .hit  (hit_all),
    .pend (pend)
  );

  e1_inj_bitpath #(
    .FR_W(FR_W), .TS_W(TS_W), .BN_W(BN_W), .SMF_LEN(SMF_LEN),
    .E1_FRAME(E1_FRAME), .E2_FRAME(E2_FRAME),
    .FAS_ERR_BIT(FAS_ERR_BIT), .NFAS_BIT(1)
  ) u_bits (
    .clk   (clk),
    .rst_n (core_rst_n),
    .bit_en(bit_en),
    .bit_in(bit_in),
    .frm   (frm_idx),
    .ts    (ts_idx),
    .bn    (bit_idx),
    .pend  (pend),
    .e1_frc(inj_ctrl[CTL_E1]),
    .e2_frc(inj_ctrl[CTL_E2]),
    .hit   (hit_bit),
    .dout  (dout)
  );

  e1_inj_railpath u_rail (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .bit_en  (bit_en),
    .p_in    (p_in),
    .n_in    (n_in),
    .los     (inj_ctrl[CTL_LOS]),
    .bpv_pend(pend[REQ_BPV]),
    .bpv_hit (bpv_hit),
    .p_out   (p_out),
    .n_out   (n_out)
  );
endmodule

// File: rtl/e1_inj_checker.sv
module e1_inj_checker #(
  parameter int E1_FRAME = 13,
  parameter int E2_FRAME = 15
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       bit_in,
  input logic [3:0] frm_idx,
  input logic [4:0] ts_idx,
  input logic [2:0] bit_idx,
  input logic [7:0] inj_ctrl,
  input logic [4:0] pend,
  input logic       p_in,
  input logic       n_in,
  input logic       dout,
  input logic       p_out,
  input logic       n_out
);
  a_r10_los_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && inj_ctrl[5]) |=> (!p_out && !n_out));

  a_r7_e1_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && inj_ctrl[6] && ts_idx == 5'd0 && bit_idx == 3'd0 &&
     frm_idx == 4'(E1_FRAME)) |=> !dout);

  a_r8_e2_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && inj_ctrl[7] && ts_idx == 5'd0 && bit_idx == 3'd0 &&
     frm_idx == 4'(E2_FRAME)) |=> !dout);

  a_r5_payload_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && pend[4] && ts_idx != 5'd0 && bit_idx == 3'd0)
      |=> (dout != $past(bit_in)));

  a_r6_payload_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && pend[4] && ts_idx != 5'd0 && bit_idx == 3'd0 && !inj_ctrl[4])
      |=> !pend[4]);

  a_r9_space_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !p_in && !n_in) |=> (!p_out && !n_out));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(dout) && $stable(p_out) && $stable(n_out)));
endmodule

bind e1_tx_err_inject e1_inj_checker #(.E1_FRAME(E1_FRAME), .E2_FRAME(E2_FRAME)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_en  (bit_en),
  .bit_in  (bit_in),
  .frm_idx (frm_idx),
  .ts_idx  (ts_idx),
  .bit_idx (bit_idx),
  .inj_ctrl(inj_ctrl),
  .pend    (pend),
  .p_in    (p_in),
  .n_in    (n_in),
  .dout    (dout),
  .p_out   (p_out),
  .n_out   (n_out)
);

// File: tb/test_e1_tx_err_inject.sv
`timescale 1ns/100ps
module test_e1_tx_err_inject;
  logic       clk, rst_n, bit_en, bit_in, p_in, n_in;
  logic [3:0] frm_idx;
  logic [4:0] ts_idx;
  logic [2:0] bit_idx;
  logic [7:0] inj_ctrl;
  logic       dout, p_out, n_out;

  e1_tx_err_inject i_e1_tx_err_inject (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .frm_idx(frm_idx), .ts_idx(ts_idx), .bit_idx(bit_idx),
    .inj_ctrl(inj_ctrl), .p_in(p_in), .n_in(n_in),
    .dout(dout), .p_out(p_out), .n_out(n_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: request[29:25], start position in multiframe[24:13], distance to flip[12:0]
  localparam logic [29:0] VEC [8] = '{
    {5'h04, 12'd0,    13'd1},    // R2 alignment word, eligible right away
    {5'h04, 12'd2,    13'd511},  // R2 position passed, next even frame
    {5'h08, 12'd0,    13'd257},  // R3 next odd frame
    {5'h08, 12'd257,  13'd512},  // R3 armed on the position itself
    {5'h02, 12'd0,    13'd2048}, // R4 C1 of second submultiframe
    {5'h02, 12'd2053, 13'd2043}, // R4 wraps into next multiframe
    {5'h10, 12'd7,    13'd1},    // R5 next timeslot
    {5'h10, 12'd255,  13'd9}     // R5 skips timeslot 0
  };

  int n_chk = 0, n_fail = 0;
  int gabs = 0, flips = 0, first_pos = -1, prev_pos = 0, req_g = 0;
  logic prev_bit = 1'b0, track = 1'b0;
  logic [14:0] lfsr = 15'h5a3c;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic [7:0] c, input logic one);
    logic [11:0] pos;
    @(negedge clk);
    if (track && dout !== prev_bit) begin
      if (flips == 0) first_pos = prev_pos;
      flips++;
    end
    pos      = gabs[11:0];
    frm_idx  = pos[11:8];
    ts_idx   = pos[7:3];
    bit_idx  = pos[2:0];
    bit_in   = one ? 1'b1 : lfsr[0];
    lfsr     = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
    prev_bit = bit_in;
    prev_pos = gabs;
    track    = 1'b1;
    inj_ctrl = c;
    bit_en   = 1'b1;
    gabs++;
  endtask

  task automatic align(input int st);
    while (gabs[11:0] != st[11:0]) tick(8'h00, 1'b0);
    flips = 0;
    first_pos = -1;
    req_g = gabs;
  endtask

  task automatic rtick(input logic p, input logic n, input logic [7:0] c);
    @(negedge clk);
    bit_en = 1'b1; p_in = p; n_in = n; inj_ctrl = c;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #950000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; p_in = 1'b0; n_in = 1'b0;
    frm_idx = '0; ts_idx = '0; bit_idx = '0; inj_ctrl = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 dout", int'(dout), 0);
    chk("R1 rails", int'({p_out, n_out}), 0);

    // table walk: one class per vector, R6 single flip per request
    for (int v = 0; v < 8; v++) begin
      align(int'(VEC[v][24:13]));
      tick({3'b000, VEC[v][29:25]}, 1'b0);
      repeat (4400) tick(8'h00, 1'b0);
      chk($sformatf("R6 flip count vec%0d", v), flips, 1);
      chk($sformatf("R2-5 flip distance vec%0d", v), first_pos - req_g, int'(VEC[v][12:0]));
    end

    // R11: three classes armed together
    align(0);
    tick(8'h1c, 1'b0);
    repeat (600) tick(8'h00, 1'b0);
    chk("R11 combined count", flips, 3);
    chk("R11 first flip", first_pos - req_g, 1);

    // R7 E1 forcing, frame 13
    align(0);
    repeat (4096) tick(8'h40, 1'b1);
    tick(8'h00, 1'b1);
    chk("R7 forced zeros", flips, 1);
    chk("R7 position", first_pos - req_g, 13 * 256);

    // R8 E2 forcing, frame 15
    align(0);
    repeat (4096) tick(8'h80, 1'b1);
    tick(8'h00, 1'b1);
    chk("R8 forced zeros", flips, 1);
    chk("R8 position", first_pos - req_g, 15 * 256);

    // line stage
    track = 1'b0;
    rtick(1'b1, 1'b0, 8'h00); chk("R9 mark passes", int'({p_out, n_out}), 2);
    rtick(1'b0, 1'b0, 8'h01); chk("R9 space passes", int'({p_out, n_out}), 0);
    rtick(1'b0, 1'b1, 8'h00); chk("R9 violation", int'({p_out, n_out}), 2);
    rtick(1'b1, 1'b0, 8'h00); chk("R9 after violation", int'({p_out, n_out}), 2);
    rtick(1'b0, 1'b1, 8'h00); chk("R9 only once", int'({p_out, n_out}), 1);
    rtick(1'b1, 1'b0, 8'h20); chk("R10 silenced p", int'({p_out, n_out}), 0);
    rtick(1'b0, 1'b1, 8'h21); chk("R10 silenced n", int'({p_out, n_out}), 0);
    rtick(1'b0, 1'b0, 8'h20); chk("R10 silenced space", int'({p_out, n_out}), 0);
    rtick(1'b1, 1'b0, 8'h00); chk("R10 held violation", int'({p_out, n_out}), 1);
    rtick(1'b0, 1'b1, 8'h00); chk("R10 normal after", int'({p_out, n_out}), 1);
    rtick(1'b1, 1'b0, 8'h00); chk("R12 setup", int'({p_out, n_out}), 2);

    begin
      logic d0;
      d0 = dout;
      @(negedge clk);
      bit_en = 1'b0; p_in = 1'b0; n_in = 1'b1; bit_in = ~d0; inj_ctrl = 8'h20;
      repeat (3) @(posedge clk);
      #1;
      chk("R12 rails hold", int'({p_out, n_out}), 2);
      chk("R12 dout hold", int'(dout), int'(d0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule